// File: doc/BRIEF.md
# DMA Controller Channel-Enable and Interrupt Register Block

This block is the control and interrupt register file of an eight-channel DMA controller. It sits on a simple 32-bit register bus that has an address, a write strobe, write data and combinational read data. It holds three kinds of state:

- a global controller enable;
- a per-channel enable word;
- five parallel interrupt classes: transfer complete, block complete, source transaction, destination transaction and error.

The channel engines report completions and faults as one-cycle pulses, one bit per channel per class. The block latches these pulses into sticky raw bits, qualifies them with per-channel masks, and drives one interrupt line.

Software changes one channel's mask or enable with a single write. The upper byte of the write data selects which channels the write touches, and the lower byte gives their new values. No read-modify-write is needed. Software acknowledges an interrupt by writing ones to the matching bits of that class's clear register. A combined status register tells the handler which classes are pending, so it can read only those status registers.

Top module: `dmac_irq_regs`

## Requirements
- R1: After a synchronous reset, the global enable reads 0, the channel enables read 0, every raw bit is 0, every mask is 0 (all channels masked) and `irq_o` is low.
- R2: The address map uses byte offsets, with class index k = 0 for transfer, 1 for block, 2 for source transaction, 3 for destination transaction and 4 for error:
  - raw register of class k at 0x2C0 + 8k;
  - status register at 0x2E8 + 8k;
  - mask register at 0x310 + 8k;
  - clear register at 0x338 + 8k;
  - combined status at 0x360;
  - global enable at 0x398;
  - channel enable at 0x3A0.
  
  Clear registers and unmapped addresses read as 0. Writes to raw, status and combined registers have no effect.
- R3: A mask write uses wdata[15:8] as per-channel write enables and wdata[7:0] as the new values. A 1 in the mask means unmasked. Channels whose enable bit is 0 keep their mask. The mask reads back in bits [7:0].
- R4: A channel-enable write uses the same enable/value scheme as R3 (0x101<<ch enables channel ch, 0x100<<ch disables it). The enabled channels read back in bits [7:0] and drive `chan_en_o`.
- R5: Writing wdata[0] to the global enable register sets the controller enable, which reads back in bit 0 and drives `ctrl_en_o`.
- R6: While the controller is globally disabled, writes to the channel-enable register have no effect.
- R7: An event pulse on a channel's bit of a class sets that raw bit on the next clock edge. Raw bits then stay set until cleared.
- R8: Writing 1 to bit ch of a class's clear register clears that class's raw bit ch. Bits written 0 are unchanged.
- R9: If an event pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R10: Each status register reads as its raw register ANDed with its mask register.
- R11: Combined-status bit k (k as in R2) is the OR of all bits of status register k. `irq_o` is the OR of the combined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_tfr | input | 8 | Transfer-complete pulses, one per channel |
| ev_blk | input | 8 | Block-complete pulses |
| ev_srct | input | 8 | Source-transaction pulses |
| ev_dstt | input | 8 | Destination-transaction pulses |
| ev_err | input | 8 | Error pulses |
| chan_en_o | output | 8 | Enabled channels |
| ctrl_en_o | output | 1 | Global controller enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Write-enable byte.** A mask or enable write with an empty enable byte must change nothing, and a write that enables one channel must leave its neighbours alone. A design that treated the low byte as a plain value would wipe the other channels.
- **Enable gating.** A channel-enable write while the controller is off must be dropped. A design that let it through would start channels while the controller is off.
- **Event/clear collision.** When an event and a clear hit the same bit in one cycle, the event must survive. A design that got this wrong would lose an interrupt that arrived during acknowledgement.
- **Clear granularity.** A clear of an unrelated bit must not disturb the raw register. A clear that ignored its data bits would acknowledge interrupts that have not been serviced.
- **Read-only raw bits.** A write to a raw register must not alter it.
- **Combined-status order.** Each class's pending bit must land in the right position of the combined word, so that a handler reading it dispatches to the right status register.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int NUM_CH  = 8;
    localparam int NUM_IRQ = 5;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int STRIDE  = 8;

    localparam logic [ADDR_W-1:0] OFS_RAW  = 12'h2C0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h2E8;
    localparam logic [ADDR_W-1:0] OFS_MASK = 12'h310;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h338;
    localparam logic [ADDR_W-1:0] OFS_COMB = 12'h360;
    localparam logic [ADDR_W-1:0] OFS_GCFG = 12'h398;
    localparam logic [ADDR_W-1:0] OFS_CHEN = 12'h3A0;

    // Class order fixes the bit position in the combined status word.
    typedef enum logic [2:0] {
        IRQ_TFR  = 3'd0,
        IRQ_BLK  = 3'd1,
        IRQ_SRCT = 3'd2,
        IRQ_DSTT = 3'd3,
        IRQ_ERR  = 3'd4
    } irq_kind_e;

    typedef enum logic [1:0] {
        REG_RAW  = 2'd0,
        REG_STAT = 2'd1,
        REG_MASK = 2'd2,
        REG_CLR  = 2'd3
    } class_reg_e;

    typedef struct packed {
        logic              hit;
        class_reg_e        kind;
        logic [2:0]        idx;
    } class_dec_t;

    function automatic logic [ADDR_W-1:0] class_ofs(logic [ADDR_W-1:0] base, int k);
        return base + ADDR_W'(STRIDE * k);
    endfunction

endpackage

// File: rtl/dmac_bitwe_reg.sv
// Register whose bits are written only where a per-bit write enable is set.
module dmac_bitwe_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_sel,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);

    logic [W-1:0] sel_eff;

    always_comb begin
        sel_eff = wr_stb ? wr_sel : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else begin
            q <= (q & ~sel_eff) | (wr_val & sel_eff);
        end
    end

    // R3 / R4: with no write strobe the register holds its value
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(q));

    // R3 / R4: channels not selected by the enable byte keep their bit
    a_r3_unselected_kept: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (((q ^ $past(q)) & ~$past(wr_sel)) == '0));

    // R3 / R4: selected channels take the written value
    a_r4_selected_taken: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> ((q & $past(wr_sel)) == ($past(wr_val) & $past(wr_sel))));

endmodule

// File: rtl/dmac_irq_raw.sv
// Sticky raw interrupt bits of one class: set by events, cleared by writes.
module dmac_irq_raw #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_stb ? clr_bits : '0;
    end

    // Event term is ORed last, so an event beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_eff) | ev;
        end
    end

    // R7 / R9: every pulsed bit is set one cycle later, clear or not
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((q & $past(ev)) == $past(ev)));

    // R7: without a clear, set bits stay set
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_stb |=> ((q & $past(q)) == $past(q)));

    // R8: cleared bits without a concurrent event are zero next cycle
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> ((q & $past(clr_bits) & ~$past(ev)) == '0));

    // R8: bits not named by the clear and not pulsed are unchanged
    a_r8_clear_narrow: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> (((q ^ $past(q)) & ~$past(clr_bits) & ~$past(ev)) == '0));

endmodule

// File: rtl/dmac_irq_regs.sv
module dmac_irq_regs
    import dmac_regs_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int N_IRQ = NUM_IRQ,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_CH-1:0] ev_tfr,
    input  logic [N_CH-1:0] ev_blk,
    input  logic [N_CH-1:0] ev_srct,
    input  logic [N_CH-1:0] ev_dstt,
    input  logic [N_CH-1:0] ev_err,
    output logic [N_CH-1:0] chan_en_o,
    output logic            ctrl_en_o,
    output logic            irq_o
);

    localparam int SEL_LO = N_CH;
    localparam int SEL_HI = 2 * N_CH - 1;

    logic [N_IRQ-1:0][N_CH-1:0] ev_all;
    logic [N_IRQ-1:0][N_CH-1:0] raw_q;
    logic [N_IRQ-1:0][N_CH-1:0] mask_q;
    logic [N_IRQ-1:0][N_CH-1:0] stat;
    logic [N_IRQ-1:0]           comb;
    logic [N_IRQ-1:0]           mask_stb;
    logic [N_IRQ-1:0]           clr_stb;
    logic                       gcfg_q;
    logic                       chen_stb;
    logic [N_CH-1:0]            wr_sel;
    logic [N_CH-1:0]            wr_val;
    logic                       unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:SEL_HI+1];

    always_comb begin
        ev_all[IRQ_TFR]  = ev_tfr;
        ev_all[IRQ_BLK]  = ev_blk;
        ev_all[IRQ_SRCT] = ev_srct;
        ev_all[IRQ_DSTT] = ev_dstt;
        ev_all[IRQ_ERR]  = ev_err;
    end

    assign wr_sel   = bus_wdata[SEL_HI:SEL_LO];
    assign wr_val   = bus_wdata[N_CH-1:0];
    assign chen_stb = bus_we && (bus_addr == OFS_CHEN) && gcfg_q;

    // Global controller enable
    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q <= 1'b0;
        end else if (bus_we && bus_addr == OFS_GCFG) begin
            gcfg_q <= bus_wdata[0];
        end
    end

    dmac_bitwe_reg #(.W(N_CH), .RST_VAL('0)) u_chen (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (chen_stb),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .q      (chan_en_o)
    );

    for (genvar k = 0; k < N_IRQ; k++) begin : g_class
        assign mask_stb[k] = bus_we && (bus_addr == class_ofs(OFS_MASK, k));
        assign clr_stb[k]  = bus_we && (bus_addr == class_ofs(OFS_CLR, k));

        dmac_bitwe_reg #(.W(N_CH), .RST_VAL('0)) u_mask (
            .clk    (clk),
            .rst    (rst),
            .wr_stb (mask_stb[k]),
            .wr_sel (wr_sel),
            .wr_val (wr_val),
            .q      (mask_q[k])
        );

        dmac_irq_raw #(.W(N_CH)) u_raw (
            .clk      (clk),
            .rst      (rst),
            .ev       (ev_all[k]),
            .clr_stb  (clr_stb[k]),
            .clr_bits (wr_val),
            .q        (raw_q[k])
        );

        assign stat[k] = raw_q[k] & mask_q[k];
        assign comb[k] = |stat[k];
    end

    assign ctrl_en_o = gcfg_q;
    assign irq_o     = |comb;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_IRQ; k++) begin
            if (bus_addr == class_ofs(OFS_RAW, k))  bus_rdata[N_CH-1:0] = raw_q[k];
            if (bus_addr == class_ofs(OFS_STAT, k)) bus_rdata[N_CH-1:0] = stat[k];
            if (bus_addr == class_ofs(OFS_MASK, k)) bus_rdata[N_CH-1:0] = mask_q[k];
        end
        if (bus_addr == OFS_COMB) bus_rdata[N_IRQ-1:0] = comb;
        if (bus_addr == OFS_GCFG) bus_rdata[0]         = gcfg_q;
        if (bus_addr == OFS_CHEN) bus_rdata[N_CH-1:0]  = chan_en_o;
    end

    // R6: channel enables cannot change while the controller is off
    a_r6_gated_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en_o |=> $stable(chan_en_o));

    // R5: the global enable moves only on a write to its address
    a_r5_gcfg_write_only: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_GCFG) |=> $stable(ctrl_en_o));

    // R10 / R11: an interrupt needs at least one unmasked channel
    a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|mask_q));

    // R11: an interrupt needs at least one latched raw bit
    a_r11_irq_needs_raw: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|raw_q));

endmodule

// File: tb/dmac_irq_regs_bench.sv
`timescale 1ns/1ps
module dmac_irq_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ev_tfr = '0, ev_blk = '0, ev_srct = '0, ev_dstt = '0, ev_err = '0;
    logic [7:0]  chan_en_o;
    logic        ctrl_en_o;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dmac_irq_regs u_dmac_irq_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tfr(ev_tfr), .ev_blk(ev_blk), .ev_srct(ev_srct),
        .ev_dstt(ev_dstt), .ev_err(ev_err),
        .chan_en_o(chan_en_o), .ctrl_en_o(ctrl_en_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h398, 32'h0000_0001, 12'h398, 32'h01},  // R5 enable controller
        '{1'b1, 12'h3A0, 32'h0000_0404, 12'h3A0, 32'h04},  // R4 enable ch2
        '{1'b1, 12'h3A0, 32'h0000_8080, 12'h3A0, 32'h84},  // R4 enable ch7, ch2 kept
        '{1'b1, 12'h3A0, 32'h0000_0400, 12'h3A0, 32'h80},  // R4 disable ch2
        '{1'b1, 12'h310, 32'h0000_FFFF, 12'h310, 32'hFF},  // R3 unmask all
        '{1'b1, 12'h310, 32'h0000_0200, 12'h310, 32'hFD},  // R3 mask ch1 only
        '{1'b1, 12'h318, 32'h0000_0808, 12'h318, 32'h08},  // R3 block class ch3
        '{1'b1, 12'h318, 32'h0000_00FF, 12'h318, 32'h08},  // R3 empty enable byte
        '{1'b1, 12'h310, 32'h0000_FF00, 12'h310, 32'h00},  // R3 mask all
        '{1'b1, 12'h398, 32'h0000_0000, 12'h398, 32'h00},  // R5 disable controller
        '{1'b1, 12'h3A0, 32'h0000_FFFF, 12'h3A0, 32'h80}   // R6 ignored while off
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input int kind, input logic [7:0] bits);
        @(negedge clk);
        case (kind)
            0: ev_tfr = bits;
            1: ev_blk = bits;
            2: ev_srct = bits;
            3: ev_dstt = bits;
            default: ev_err = bits;
        endcase
        @(negedge clk);
        ev_tfr = '0; ev_blk = '0; ev_srct = '0; ev_dstt = '0; ev_err = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_reset_state();
        rd_check("R1 gcfg", 12'h398, 32'h0);
        rd_check("R1 chen", 12'h3A0, 32'h0);
        check("R1 chan_en_o", {24'h0, chan_en_o}, 32'h0);
        check("R1 ctrl_en_o", {31'h0, ctrl_en_o}, 32'h0);
        check("R1 irq_o", {31'h0, irq_o}, 32'h0);
        for (int k = 0; k < 5; k++) begin
            rd_check("R1 raw", 12'(12'h2C0 + 8 * k), 32'h0);
            rd_check("R1 mask", 12'(12'h310 + 8 * k), 32'h0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].waddr, VEC[i].wdata);
            rd_check($sformatf("vector %0d (R3/R4/R5/R6)", i), VEC[i].raddr, VEC[i].exp);
        end
        check("R4 chan_en_o port", {24'h0, chan_en_o}, 32'h80);
        check("R5 ctrl_en_o port", {31'h0, ctrl_en_o}, 32'h0);

        // error class, ch3
        pulse(4, 8'h08);
        rd_check("R7 raw err set", 12'h2E0, 32'h08);
        rd_check("R10 status err masked", 12'h308, 32'h0);
        check("R11 irq masked", {31'h0, irq_o}, 32'h0);
        wr(12'h2E0, 32'h0);
        rd_check("R2 raw write ignored", 12'h2E0, 32'h08);
        wr(12'h330, 32'h0808);
        rd_check("R10 status err", 12'h308, 32'h08);
        rd_check("R11 combined err bit4", 12'h360, 32'h10);
        check("R11 irq up", {31'h0, irq_o}, 32'h1);
        wr(12'h358, 32'h01);
        rd_check("R8 clear other bit", 12'h2E0, 32'h08);
        rd_check("R2 clear reads zero", 12'h358, 32'h0);
        wr(12'h358, 32'h08);
        rd_check("R8 clear bit", 12'h2E0, 32'h0);
        check("R11 irq down", {31'h0, irq_o}, 32'h0);

        // collision: event and clear on the same bit in one cycle
        @(negedge clk);
        bus_addr = 12'h358; bus_wdata = 32'h08; bus_we = 1'b1; ev_err = 8'h08;
        @(negedge clk);
        bus_we = 1'b0; ev_err = '0;
        rd_check("R9 event wins", 12'h2E0, 32'h08);
        wr(12'h358, 32'h08);
        rd_check("R8 clear after collision", 12'h2E0, 32'h0);

        // combined-status ordering across classes
        pulse(0, 8'h01);
        rd_check("R11 tfr masked", 12'h360, 32'h0);
        wr(12'h310, 32'h0101);
        rd_check("R11 combined tfr bit0", 12'h360, 32'h01);
        check("R11 irq tfr", {31'h0, irq_o}, 32'h1);
        pulse(1, 8'h08);
        rd_check("R7 raw blk", 12'h2C8, 32'h08);
        rd_check("R10 status blk", 12'h2F0, 32'h08);
        rd_check("R11 combined blk bit1", 12'h360, 32'h03);
        pulse(2, 8'h20);
        rd_check("R7 raw srct", 12'h2D0, 32'h20);
        pulse(3, 8'h40);
        rd_check("R7 raw dstt", 12'h2D8, 32'h40);
        wr(12'h328, 32'h4040);
        rd_check("R10 status dstt", 12'h300, 32'h40);
        rd_check("R11 combined dstt bit3", 12'h360, 32'h0B);
        rd_check("R2 unmapped reads zero", 12'h3FC, 32'h0);

        // reset again with state present
        do_reset();
        check_reset_state();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule